// File: doc/BRIEF.md
# Memory Fault Capture and Board Sizing Unit

This unit records the first memory or bus fault it sees and then holds that record until software lets it go. One fault strobe loads four things at once: the physical address of the fault, the two six-bit ECC syndromes for the upper and lower halfwords, and a twelve-bit group of bus-master and access-type flags. The same strobe raises a frozen flag. While that flag is high the record does not change. A write that clears the flag allows the next fault to be captured.

The unit also shows the presence and size straps of up to four memory boards. A read index selects one of four aliased status words. All four carry the selected slot's three strap bits in their low bits. Only the word at index 0 also carries the captured syndrome and flag fields. The unit adds up the total contiguous memory in bytes from the lowest slot upward. It stops at the first slot that is not equipped, so boards above a gap are not counted.

Top module: `mfu_fault_unit`

## Requirements
- R1: After reset, frozen is 0, the fault-address word is 0 and status word 0 carries zeros in bits 31:3.
- R2: A fault strobe while not frozen loads the fault address into bits 25:0 of the fault-address word on the next clock edge, with bits 31:26 zero, and sets frozen.
- R3: The same capture places the upper syndrome in bits 31:26, the lower syndrome in bits 25:20 and the 12 flag bits in bits 19:8 of status word 0 (flag input bit k lands in bit 8+k).
- R4: While frozen and not being cleared, a fault strobe leaves the address, syndromes, flags and frozen unchanged.
- R5: A clear request with no fault strobe drops frozen on the next edge and keeps the captured contents.
- R6: A clear request together with a fault strobe in the same cycle captures the new fault, and frozen stays 1.
- R7: Status word k (read index k) reports slot k's straps in bits 2:0. Bit 2 means the board is equipped. Bits 1:0 give the size: 00 = 2 MB, 01 = 8 MB, 10 = 4 MB, 11 = 16 MB.
- R8: Bits 7:3 of every status word read as zero, and status words 1 to 3 read zero in bits 31:3.
- R9: The total size output equals the sum of the slot sizes from slot 0 upward, stopping before the first slot whose equipped bit is 0.
- R10: If slot 0 is not equipped the total is 0. Four equipped 16 MB boards give 0x4000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_valid | input | 1 | Fault strobe from the memory/bus fabric |
| fault_addr | input | 26 | Physical address of the fault |
| fault_syn_hi | input | 6 | Upper halfword ECC syndrome |
| fault_syn_lo | input | 6 | Lower halfword ECC syndrome |
| fault_flags | input | 12 | Bus-master and access-type flags |
| clr_frozen | input | 1 | Software request to re-arm capture |
| slot_cfg | input | 12 | Three strap bits per slot, slot k in bits 3k+2:3k |
| rd_idx | input | 2 | Status word index (0 to 3) |
| frozen | output | 1 | Fault record held |
| fault_addr_word | output | 32 | Fault-address register view |
| rd_data | output | 32 | Selected status word |
| total_bytes | output | 27 | Contiguous installed memory in bytes |

## Verification
Capture and re-arm can both happen in one cycle: a fault strobe can arrive on the same edge as the software clear of the frozen flag. The bench drives both together while the unit is frozen. It then expects the new address and syndromes to appear one edge later with frozen still high, rather than a dropped flag or the old record. It also drives a clear on its own and a strobe on its own, so that the three outcomes can be told apart.

// File: rtl/mfu_pkg.sv
package mfu_pkg;
    localparam int ADDR_W = 26;
    localparam int SYN_W  = 6;
    localparam int FLAG_W = 12;
    localparam int SLOTS  = 4;
    localparam int STRAP_W = 3;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [SYN_W-1:0]  syn_hi;
        logic [SYN_W-1:0]  syn_lo;
        logic [FLAG_W-1:0] flags;
        logic              frozen;
    } fault_rec_t;
endpackage

// File: rtl/mfu_capture.sv
module mfu_capture
    import mfu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_valid,
    input  logic [ADDR_W-1:0] fault_addr,
    input  logic [SYN_W-1:0]  fault_syn_hi,
    input  logic [SYN_W-1:0]  fault_syn_lo,
    input  logic [FLAG_W-1:0] fault_flags,
    input  logic              clr_frozen,
    output fault_rec_t        rec
);
    fault_rec_t rec_d, rec_q;

    always_comb begin
        rec_d = rec_q;
        // A clear in the same cycle re-arms, so the coincident fault is taken.
        if (fault_valid && (!rec_q.frozen || clr_frozen)) begin
            rec_d.addr   = fault_addr;
            rec_d.syn_hi = fault_syn_hi;
            rec_d.syn_lo = fault_syn_lo;
            rec_d.flags  = fault_flags;
            rec_d.frozen = 1'b1;
        end else if (clr_frozen) begin
            rec_d.frozen = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign rec = rec_q;
endmodule

// File: rtl/mfu_sizer.sv
module mfu_sizer #(
    parameter int N_SLOT  = 4,
    parameter int STRAP_W = 3,
    localparam int TOT_W  = 25 + $clog2(N_SLOT)
) (
    input  logic [N_SLOT*STRAP_W-1:0] slot_cfg,
    output logic [TOT_W-1:0]          total_bytes
);
    function automatic logic [TOT_W-1:0] board_bytes(input logic [1:0] code);
        logic [TOT_W-1:0] one;
        one = {{(TOT_W-1){1'b0}}, 1'b1};
        case (code)
            2'b00:   board_bytes = one << 21;
            2'b01:   board_bytes = one << 23;
            2'b10:   board_bytes = one << 22;
            default: board_bytes = one << 24;
        endcase
    endfunction

    logic [N_SLOT:0]  chain;
    logic [TOT_W-1:0] part [N_SLOT];

    assign chain[0] = 1'b1;

    for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
        logic eq;
        assign eq           = slot_cfg[i*STRAP_W + 2];
        assign chain[i+1]   = chain[i] & eq;
        assign part[i]      = chain[i+1] ? board_bytes(slot_cfg[i*STRAP_W +: 2]) : '0;
    end

    always_comb begin
        total_bytes = '0;
        for (int i = 0; i < N_SLOT; i++) total_bytes = total_bytes + part[i];
    end
endmodule

// File: rtl/mfu_regview.sv
module mfu_regview
    import mfu_pkg::*;
#(
    parameter int N_SLOT = 4,
    localparam int IDX_W = $clog2(N_SLOT)
) (
    input  fault_rec_t                rec,
    input  logic [N_SLOT*STRAP_W-1:0] slot_cfg,
    input  logic [IDX_W-1:0]          rd_idx,
    output logic [31:0]               fault_addr_word,
    output logic [31:0]               rd_data
);
    localparam int FIELD_W = 2*SYN_W + FLAG_W;
    localparam int PAD_W   = 32 - FIELD_W - STRAP_W;

    logic [FIELD_W-1:0] field;

    assign field           = (rd_idx == '0) ? {rec.syn_hi, rec.syn_lo, rec.flags} : '0;
    assign fault_addr_word = {{(32-ADDR_W){1'b0}}, rec.addr};
    assign rd_data         = {field, {PAD_W{1'b0}}, slot_cfg[rd_idx*STRAP_W +: STRAP_W]};
endmodule

// File: rtl/mfu_fault_unit.sv
module mfu_fault_unit
    import mfu_pkg::*;
#(
    parameter int N_SLOT = SLOTS,
    localparam int IDX_W = $clog2(N_SLOT),
    localparam int TOT_W = 25 + $clog2(N_SLOT)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fault_valid,
    input  logic [ADDR_W-1:0]         fault_addr,
    input  logic [SYN_W-1:0]          fault_syn_hi,
    input  logic [SYN_W-1:0]          fault_syn_lo,
    input  logic [FLAG_W-1:0]         fault_flags,
    input  logic                      clr_frozen,
    input  logic [N_SLOT*STRAP_W-1:0] slot_cfg,
    input  logic [IDX_W-1:0]          rd_idx,
    output logic                      frozen,
    output logic [31:0]               fault_addr_word,
    output logic [31:0]               rd_data,
    output logic [TOT_W-1:0]          total_bytes
);
    fault_rec_t rec;

    mfu_capture u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .fault_valid  (fault_valid),
        .fault_addr   (fault_addr),
        .fault_syn_hi (fault_syn_hi),
        .fault_syn_lo (fault_syn_lo),
        .fault_flags  (fault_flags),
        .clr_frozen   (clr_frozen),
        .rec          (rec)
    );

    mfu_sizer #(.N_SLOT(N_SLOT), .STRAP_W(STRAP_W)) u_size (
        .slot_cfg    (slot_cfg),
        .total_bytes (total_bytes)
    );

    mfu_regview #(.N_SLOT(N_SLOT)) u_view (
        .rec             (rec),
        .slot_cfg        (slot_cfg),
        .rd_idx          (rd_idx),
        .fault_addr_word (fault_addr_word),
        .rd_data         (rd_data)
    );

    assign frozen = rec.frozen;
endmodule

// File: rtl/mfu_fault_chk.sv
module mfu_fault_chk
    import mfu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              fault_valid,
    input logic [ADDR_W-1:0] fault_addr,
    input logic [SYN_W-1:0]  fault_syn_hi,
    input logic              clr_frozen,
    input logic [11:0]       slot_cfg,
    input logic [1:0]        rd_idx,
    input logic              frozen,
    input logic [31:0]       fault_addr_word,
    input logic [31:0]       rd_data,
    input logic [26:0]       total_bytes
);
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && !frozen) |=> (frozen && fault_addr_word[ADDR_W-1:0] == $past(fault_addr)));

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !clr_frozen) |=> (frozen && $stable(fault_addr_word)));

    a_r5_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && clr_frozen && !fault_valid) |=> (!frozen && $stable(fault_addr_word)));

    a_r6_clear_and_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_frozen && fault_valid) |=> (frozen && fault_addr_word[ADDR_W-1:0] == $past(fault_addr)
                                         && rd_idx != 2'd0 || rd_data[31:26] == $past(fault_syn_hi)));

    a_r8_alias_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx != 2'd0) |-> (rd_data[31:3] == 29'd0));

    a_r10_empty_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_cfg[2]) |-> (total_bytes == 27'd0));
endmodule

bind mfu_fault_unit mfu_fault_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .fault_valid     (fault_valid),
    .fault_addr      (fault_addr),
    .fault_syn_hi    (fault_syn_hi),
    .clr_frozen      (clr_frozen),
    .slot_cfg        (slot_cfg),
    .rd_idx          (rd_idx),
    .frozen          (frozen),
    .fault_addr_word (fault_addr_word),
    .rd_data         (rd_data),
    .total_bytes     (total_bytes)
);

// File: tb/tb_mfu_fault_unit.sv
`timescale 1ns/1ps
module tb_mfu_fault_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        fault_valid;
    logic [25:0] fault_addr;
    logic [5:0]  fault_syn_hi, fault_syn_lo;
    logic [11:0] fault_flags;
    logic        clr_frozen;
    logic [11:0] slot_cfg;
    logic [1:0]  rd_idx;
    logic        frozen;
    logic [31:0] fault_addr_word, rd_data;
    logic [26:0] total_bytes;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mfu_fault_unit dut (.*);

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic longint exp_total(input logic [11:0] cfg);
        longint t = 0;
        for (int i = 0; i < 4; i++) begin
            if (!cfg[i*3+2]) break;
            case (cfg[i*3 +: 2])
                2'b00: t += 2*1024*1024;
                2'b01: t += 8*1024*1024;
                2'b10: t += 4*1024*1024;
                default: t += 16*1024*1024;
            endcase
        end
        return t;
    endfunction

    // Drive one cycle of stimulus at negedge, then sample at the following negedge.
    task automatic step(input bit fv, input bit clr, input logic [25:0] a,
                        input logic [5:0] sh, input logic [5:0] sl, input logic [11:0] fl);
        fault_valid = fv; clr_frozen = clr; fault_addr = a;
        fault_syn_hi = sh; fault_syn_lo = sl; fault_flags = fl;
        @(negedge clk);
        fault_valid = 0; clr_frozen = 0;
    endtask

    task automatic check_rec(input string req, input logic [25:0] a,
                             input logic [5:0] sh, input logic [5:0] sl, input logic [11:0] fl);
        rd_idx = 2'd0; #0.1;
        check(fault_addr_word == {6'd0, a}, req, fault_addr_word, {6'd0, a});
        check(rd_data[31:8] == {sh, sl, fl}, req, rd_data[31:8], {sh, sl, fl});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; fault_valid = 0; clr_frozen = 0; fault_addr = '0;
        fault_syn_hi = '0; fault_syn_lo = '0; fault_flags = '0;
        slot_cfg = '0; rd_idx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check(frozen == 0, "R1", frozen, 0);
        check(fault_addr_word == 0, "R1", fault_addr_word, 0);
        check(rd_data[31:3] == 0, "R1", rd_data[31:3], 0);

        // R2/R3 capture across several patterns, each followed by a lone clear (R5)
        for (int i = 0; i < 16; i++) begin
            logic [25:0] a;
            logic [5:0]  sh, sl;
            logic [11:0] fl;
            a  = 26'(32'h0123457 * (i + 1) ^ (32'h3FFFFFF >> i));
            sh = 6'(i * 5 + 1);
            sl = 6'(63 - i * 3);
            fl = 12'(1 << (i % 12)) ^ 12'(i * 77);
            step(1, 0, a, sh, sl, fl);
            check(frozen == 1, "R2", frozen, 1);
            check(fault_addr_word == {6'd0, a}, "R2", fault_addr_word, {6'd0, a});
            check_rec("R3", a, sh, sl, fl);
            // R4: another fault while frozen is ignored
            step(1, 0, ~a, ~sh, ~sl, ~fl);
            check(frozen == 1, "R4", frozen, 1);
            check_rec("R4", a, sh, sl, fl);
            // R5: lone clear drops frozen and keeps contents
            step(0, 1, '0, '0, '0, '0);
            check(frozen == 0, "R5", frozen, 0);
            check_rec("R5", a, sh, sl, fl);
        end

        // R6: frozen, then clear and fault in the same cycle
        step(1, 0, 26'h1111111, 6'h11, 6'h22, 12'hABC);
        step(1, 1, 26'h2BCDEF0, 6'h3E, 6'h05, 12'h5A5);
        check(frozen == 1, "R6", frozen, 1);
        check_rec("R6", 26'h2BCDEF0, 6'h3E, 6'h05, 12'h5A5);
        step(0, 1, '0, '0, '0, '0);
        check(frozen == 0, "R6", frozen, 0);

        // R7/R8: strap view on all four status words, R9/R10 sizing, full sweep
        for (int c = 0; c < 4096; c++) begin
            slot_cfg = 12'(c);
            for (int k = 0; k < 4; k++) begin
                rd_idx = 2'(k); #0.1;
                check(rd_data[2:0] == slot_cfg[k*3 +: 3], "R7", rd_data[2:0], slot_cfg[k*3 +: 3]);
                check(rd_data[7:3] == 0, "R8", rd_data[7:3], 0);
                if (k != 0) check(rd_data[31:3] == 0, "R8", rd_data[31:3], 0);
            end
            check(longint'(total_bytes) == exp_total(slot_cfg), "R9", total_bytes, exp_total(slot_cfg));
            if (c % 64 == 63) @(negedge clk);
        end

        // R10 corner cases
        slot_cfg = 12'b111_111_111_011; #0.1;
        check(total_bytes == 0, "R10", total_bytes, 0);
        slot_cfg = 12'b111_111_111_111; #0.1;
        check(total_bytes == 27'h4000000, "R10", total_bytes, 27'h4000000);
        @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule